// File: doc/BRIEF.md
# Smart Card Character Receiver with Error Signal

This block receives characters from the single shared I/O line of a smart card. A character is a start bit, eight data bits sent least significant first, and one even parity bit. The line is sampled once per elementary time unit (etu), and an etu is a programmable number of system clocks. When parity fails, the receiver pulls the open-drain line low for one etu, starting half an etu after the parity bit ends. The sender reads that low level as a request to send the character again.

For a character that passes the check, the line stays released in the error slot. The byte goes into a receive data register and a data-full flag is set. A host or DMA reads the byte and strobes an acknowledge, which clears the flag. A failed check sets a parity-error flag and leaves the data register and the data-full flag untouched. Receive and error interrupt requests are level outputs that an enable input gates. After each character the receiver ignores the line through the error slot and one guard etu, so its own error pulse cannot start a new frame.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rdf_o`, `per_o`, `ovr_o`, `rxi_o`, `eri_o` and `io_oe_o` are all 0.
- R2: A frame whose ninth bit makes the count of ones across data and parity even loads the data bits into `rd_data_o` (first data bit = bit 0) and sets `rdf_o`. `per_o` is not set.
- R3: A frame with odd parity sets `per_o`. It does not set `rdf_o` and does not change `rd_data_o`.
- R4: On an odd-parity frame, `io_oe_o` is 1 from about 10.5 etu to 11.5 etu after the start edge and 0 outside that window. On an even-parity frame it stays 0.
- R5: A one-cycle `rd_ack_i` clears `rdf_o` on the next clock.
- R6: A good frame that completes while `rdf_o` is set sets `ovr_o`. It leaves `rd_data_o` and `rdf_o` unchanged. `ovr_clr_i` clears `ovr_o`.
- R7: A `per_o` still set from an earlier frame does not block reception: the repeated good frame still sets `rdf_o` and loads its data.
- R8: `rxi_o` is `rdf_o` gated by `rie_i`. `eri_o` is (`per_o` or `ovr_o`) gated by `rie_i`.
- R9: A low pulse on the line that has ended by mid start bit does not start a frame and changes no flag.
- R10: The receiver's own error-signal low is not taken as a start bit. With the line otherwise idle after an errored frame, no further error signal is driven.
- R11: `per_clr_i` clears `per_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| etu_div_i | input | ETU_W | System clocks per etu (at least 4) |
| rie_i | input | 1 | Interrupt request enable |
| io_i | input | 1 | Level sensed on the card I/O line |
| io_oe_o | output | 1 | Pulls the open-drain line low when 1 |
| rd_data_o | output | 8 | Receive data register |
| rd_ack_i | input | 1 | Read strobe from host or DMA; clears data-full |
| per_clr_i | input | 1 | Clears the parity-error flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rdf_o | output | 1 | Receive data full |
| per_o | output | 1 | Parity error |
| ovr_o | output | 1 | Overrun |
| rxi_o | output | 1 | Receive-complete interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
The line passes a two-stage synchronizer, and the frame then starts on the following clock. Each mid-bit sample therefore lands about 2.5 clocks plus half an etu after the bench drives the bit. The flags follow the parity sample by two clocks. The bench uses 8 clocks per etu and reads the error-signal output at 10.25, 11.25 and 12.25 etu. Those points sit a safe distance from both window edges, at roughly 10.8 and 11.8 etu. Flags are read at 14 etu, well after they settle. Acknowledge and clear strobes are checked one clock after they are applied.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic {ST_IDLE, ST_FRAME} rx_state_e;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned IDX_W     = 4;
  // bit slot indices inside a frame (etu count from start edge)
  localparam logic [IDX_W-1:0] SLOT_START = 4'd0;
  localparam logic [IDX_W-1:0] SLOT_PAR   = 4'd9;
  localparam logic [IDX_W-1:0] SLOT_ERR   = 4'd10;
  localparam logic [IDX_W-1:0] SLOT_REL   = 4'd11;
  localparam logic [IDX_W-1:0] SLOT_DONE  = 4'd12;
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end
  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sc_rx_etu.sv
module sc_rx_etu #(
  parameter int unsigned ETU_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ETU_W-1:0] div_i,
  output logic             mid_o,
  output logic             wrap_o
);
  logic [ETU_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || wrap_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
  assign mid_o  = run_i && (cnt_q == (div_i >> 1));
  assign wrap_o = run_i && (cnt_q == div_i - 1'b1);
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_s_i,
  input  logic                 mid_i,
  input  logic                 wrap_i,
  output logic                 run_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 good_o,
  output logic                 bad_o,
  output logic                 oe_o
);
  rx_state_e            state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      err_q   <= 1'b0;
      good_o  <= 1'b0;
      bad_o   <= 1'b0;
      oe_o    <= 1'b0;
    end else begin
      good_o <= 1'b0;
      bad_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (!io_s_i) state_q <= ST_FRAME;
        end
        ST_FRAME: begin
          if (wrap_i) idx_q <= idx_q + 1'b1;
          if (mid_i) begin
            if (idx_q == SLOT_START) begin
              if (io_s_i) state_q <= ST_IDLE;  // glitch
            end else if (idx_q < SLOT_PAR) begin
              sh_q <= {io_s_i, sh_q[DATA_BITS-1:1]};
            end else if (idx_q == SLOT_PAR) begin
              err_q  <= ^{sh_q, io_s_i};
              good_o <= ~^{sh_q, io_s_i};
              bad_o  <= ^{sh_q, io_s_i};
            end else if (idx_q == SLOT_ERR) begin
              oe_o <= err_q;
            end else if (idx_q == SLOT_REL) begin
              oe_o <= 1'b0;
            end else if (idx_q == SLOT_DONE) begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == ST_FRAME);
  assign data_o = sh_q;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int unsigned ETU_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ETU_W-1:0] etu_div_i,
  input  logic             rie_i,
  input  logic             io_i,
  output logic             io_oe_o,
  output logic [7:0]       rd_data_o,
  input  logic             rd_ack_i,
  input  logic             per_clr_i,
  input  logic             ovr_clr_i,
  output logic             rdf_o,
  output logic             per_o,
  output logic             ovr_o,
  output logic             rxi_o,
  output logic             eri_o
);
  logic                 io_s, run, mid, wrap, good_w, bad_w;
  logic [DATA_BITS-1:0] shifted;

  sc_rx_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_i(io_i), .q_o(io_s)
  );

  sc_rx_etu #(.ETU_W(ETU_W)) i_etu (
    .clk_i, .rst_ni, .run_i(run), .div_i(etu_div_i), .mid_o(mid), .wrap_o(wrap)
  );

  sc_rx_frame i_frame (
    .clk_i, .rst_ni, .io_s_i(io_s), .mid_i(mid), .wrap_i(wrap),
    .run_o(run), .data_o(shifted), .good_o(good_w), .bad_o(bad_w), .oe_o(io_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rdf_o     <= 1'b0;
      per_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      if (good_w) begin
        if (rdf_o && !rd_ack_i) ovr_o <= 1'b1;
        else begin
          rdf_o     <= 1'b1;
          rd_data_o <= shifted;
        end
      end else if (rd_ack_i) begin
        rdf_o <= 1'b0;
      end
      if (bad_w)          per_o <= 1'b1;
      else if (per_clr_i) per_o <= 1'b0;
      if (ovr_clr_i && !good_w) ovr_o <= 1'b0;
    end
  end

  assign rxi_o = rie_i & rdf_o;
  assign eri_o = rie_i & (per_o | ovr_o);
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_ack_i,
  input logic       good_w,
  input logic       bad_w,
  input logic       io_oe_o,
  input logic       rdf_o,
  input logic       per_o,
  input logic       rie_i,
  input logic       rxi_o,
  input logic       eri_o,
  input logic [7:0] rd_data_o
);
  p_no_rdf_on_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_w |=> !$rose(rdf_o));
  p_oe_needs_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_oe_o) |-> per_o);
  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_i && !good_w |=> !rdf_o);
  p_data_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdf_o && !rd_ack_i |=> $stable(rd_data_o));
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rie_i |-> !rxi_o && !eri_o);
  p_good_bad_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(good_w && bad_w));
endmodule

bind sc_char_rx sc_char_rx_chk i_chk (
  .clk_i, .rst_ni, .rd_ack_i, .good_w, .bad_w, .io_oe_o,
  .rdf_o, .per_o, .rie_i, .rxi_o, .eri_o, .rd_data_o
);

// File: tb/test_sc_char_rx.sv
module test_sc_char_rx;
  localparam int ETU = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rie = 1'b0, io_drv = 1'b1, ack = 1'b0, pclr = 1'b0, oclr = 1'b0;
  logic io_oe, rdf, per, ovr, rxi, eri, io_line;
  logic [7:0] rdata;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;
  assign io_line = io_drv & ~io_oe;

  sc_char_rx #(.ETU_W(12)) i_sc_char_rx (
    .clk_i(clk), .rst_ni(rst_n), .etu_div_i(12'(ETU)), .rie_i(rie),
    .io_i(io_line), .io_oe_o(io_oe), .rd_data_o(rdata), .rd_ack_i(ack),
    .per_clr_i(pclr), .ovr_clr_i(oclr), .rdf_o(rdf), .per_o(per),
    .ovr_o(ovr), .rxi_o(rxi), .eri_o(eri)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic etus(input int n);
    repeat (n * ETU) @(negedge clk);
  endtask

  // drives a full frame; returns oe at 10.25, 11.25, 12.25 etu; ends at 14 etu
  task automatic send(input logic [7:0] d, input logic flip,
                      output logic pre, output logic mid, output logic post);
    logic [9:0] bits;
    bits = {(^d) ^ flip, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      io_drv = bits[i];
      etus(1);
    end
    io_drv = 1'b1;
    repeat (2) @(negedge clk);  pre  = io_oe;
    repeat (8) @(negedge clk);  mid  = io_oe;
    repeat (8) @(negedge clk);  post = io_oe;
    repeat (14) @(negedge clk);
  endtask

  task automatic strobe_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic pre, mid, post, seen;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    chk("R1 rdf", rdf, 0); chk("R1 per", per, 0); chk("R1 ovr", ovr, 0);
    chk("R1 irq", {rxi, eri}, 0); chk("R1 oe", io_oe, 0);
    rst_n = 1'b1; rie = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0, pre, mid, post);
      chk("R4 good no oe", {pre, mid, post}, 0);
      chk("R2 data", rdata, 8'(v));
      chk("R2 rdf", rdf, 1);
      chk("R2 per", per, 0);
      chk("R8 rxi", rxi, 1);
      strobe_ack();
      chk("R5 ack clears", rdf, 0);
      chk("R8 rxi low", rxi, 0);
    end
    last = 8'd255;

    for (int v = 3; v < 256; v += 37) begin
      send(8'(v), 1'b1, pre, mid, post);
      chk("R4 oe pre", pre, 0); chk("R4 oe slot", mid, 1); chk("R4 oe post", post, 0);
      chk("R3 per", per, 1); chk("R3 rdf", rdf, 0); chk("R3 data kept", rdata, last);
      chk("R8 eri", eri, 1);
      seen = 1'b0;
      for (int k = 0; k < 14 * ETU; k++) begin
        @(negedge clk); seen |= io_oe;
      end
      chk("R10 no phantom frame", seen, 0);
      send(8'(v), 1'b0, pre, mid, post);
      chk("R7 rdf despite per", rdf, 1); chk("R7 data", rdata, 8'(v));
      last = 8'(v);
      pclr = 1'b1; @(negedge clk); pclr = 1'b0;
      chk("R11 per cleared", per, 0);
      strobe_ack();
    end

    send(8'h5A, 1'b0, pre, mid, post);
    send(8'hA5, 1'b0, pre, mid, post);
    chk("R6 ovr", ovr, 1); chk("R6 data kept", rdata, 8'h5A); chk("R6 rdf", rdf, 1);
    chk("R8 eri ovr", eri, 1);
    oclr = 1'b1; @(negedge clk); oclr = 1'b0;
    chk("R6 ovr clr", ovr, 0);
    strobe_ack();

    rie = 1'b0;
    send(8'h3C, 1'b1, pre, mid, post);
    send(8'h3C, 1'b0, pre, mid, post);
    chk("R8 rxi masked", rxi, 0); chk("R8 eri masked", eri, 0); chk("R8 rdf", rdf, 1);
    strobe_ack();
    pclr = 1'b1; @(negedge clk); pclr = 1'b0;
    rie = 1'b1;

    io_drv = 1'b0; repeat (2) @(negedge clk); io_drv = 1'b1;
    etus(14);
    chk("R9 glitch rdf", rdf, 0); chk("R9 glitch per", per, 0); chk("R9 data", rdata, 8'h3C);
    send(8'hC3, 1'b0, pre, mid, post);
    chk("R9 after glitch", rdata, 8'hC3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule